// File: doc/BRIEF.md
# MIDI Host Port with Command Acknowledge

This block sits between a host register bus and a serial MIDI line. The host sees two byte-wide locations. Offset 0 is the data port. Offset 1 takes commands when written and returns status when read. After reset the port is in command-only mode. The host must issue the enter-UART command before any MIDI traffic flows. Every accepted command places an acknowledge byte in the receive queue. Software polls that byte from the data port in the same way as MIDI input.

Bytes the host writes go into a 4-deep transmit queue. A serial engine drains the queue as 8N1 frames. The bit time is a parameterised clock divider, CLK_HZ/BAUD, which is 31.25 kbaud by default. Bytes arriving on the serial input go into a 4-deep receive queue. Inside the block, the receiver hands each byte to the queue over a valid/ready pair. The receiver holds the byte and its valid flag until it is accepted. Only an acknowledge being queued in the same cycle can withhold ready, so back-pressure lasts at most one cycle. Two level interrupt requests report an idle transmitter and pending receive data.

Top module: `midi_host_port`

## Requirements
- R1: A write at offset 1 is a command. A read at offset 1 returns status without side effects. Status bits 5..0 always read 0.
- R2: Status bit 7 reads 0 while the receive queue holds a byte, and 1 otherwise. Status bit 6 reads 1 while the 4-entry transmit queue is full, and 0 otherwise.
- R3: Command 0x3F switches to UART mode and queues the acknowledge byte 0xFE behind any bytes already in the receive queue.
- R4: Command 0xFF empties both queues, leaves UART mode, and queues 0xFE as the only receive entry.
- R5: Any other command code changes nothing: no acknowledge is queued and the mode is unchanged.
- R6: Data writes at offset 0 are dropped while not in UART mode.
- R7: Any write made while status bit 6 is 1 is discarded. The transmit queue keeps its 4 entries.
- R8: Transmitted bytes leave in write order as 8N1 frames. Each frame has a low start bit, eight data bits sent LSB first, and a high stop bit. Each bit lasts CLK_HZ/BAUD clocks, and the line idles high.
- R9: A read at offset 0 returns the oldest receive entry and removes it. A read at offset 0 with the queue empty returns 0x00.
- R10: Received frames are dropped in three cases: the port is not in UART mode, the receive queue is full, or the stop bit is sampled low.
- R11: irq_tx_empty is 1 exactly when the port is in UART mode, the transmit queue is empty and no frame is being sent. irq_rx is 1 while the receive queue is non-empty.
- R12: After reset the port is in command mode, both queues are empty, status reads 0x80, and midi_tx is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data port, 1 = command/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| midi_rx | input | 1 | Serial MIDI input |
| midi_tx | output | 1 | Serial MIDI output |
| irq_tx_empty | output | 1 | Transmitter idle request |
| irq_rx | output | 1 | Receive data pending request |

## Verification
The hardest state to reach is a full transmit queue, because the serial engine starts draining almost as soon as the first byte lands. The bench writes five bytes on alternate cycles. The first byte is taken by the engine, and the other four fill the queue. The bench then reads status bit 6 and writes a sixth byte. A scoreboard decodes the serial output and requires exactly the first five bytes to appear. A full receive queue and a framing error come from a serial driver that sends five back-to-back frames, and one frame whose stop bit is low.

// File: rtl/midi_hp_pkg.sv
package midi_hp_pkg;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART  = 8'h3F;
  localparam logic [7:0] ACK_BYTE  = 8'hFE;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/midi_hp_fifo.sv
module midi_hp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign level = cnt;
  assign dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      rp  <= '0;
      wp  <= push ? AW'(1) : '0;
      cnt <= push ? (AW+1)'(1) : '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[flush ? '0 : wp] <= din;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty);
endmodule

// File: rtl/midi_hp_tx.sv
module midi_hp_tx #(
  parameter int CPB = 6400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       line,
  output logic       busy
);
  localparam int CW = $clog2(CPB + 1);

  logic [CW-1:0] cnt;
  logic [3:0]    nbits;
  logic [8:0]    shreg;

  assign in_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      line  <= 1'b1;
      cnt   <= '0;
      nbits <= '0;
      shreg <= '1;
    end else if (!busy) begin
      if (in_valid) begin
        busy  <= 1'b1;
        line  <= 1'b0;
        shreg <= {1'b1, in_data};
        cnt   <= '0;
        nbits <= '0;
      end
    end else if (cnt == CW'(CPB - 1)) begin
      cnt <= '0;
      if (nbits == 4'd9) begin
        busy <= 1'b0;
      end else begin
        line  <= shreg[0];
        shreg <= {1'b1, shreg[8:1]};
        nbits <= nbits + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (line == 1'b0));
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> line);
endmodule

// File: rtl/midi_hp_rx.sv
module midi_hp_rx
  import midi_hp_pkg::*;
#(
  parameter int CPB = 6400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int CW   = $clog2(CPB + 1);
  localparam int HALF = CPB / 2;

  rx_state_e     st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          bit_in;

  assign bit_in = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= 2'b11;
      st        <= RX_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sync <= {sync[0], line};
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!bit_in) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= bit_in ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == CW'(CPB - 1)) begin
            cnt   <= '0;
            shreg <= {bit_in, shreg[7:1]};
            bidx  <= bidx + 1'b1;
            if (bidx == 3'd7) st <= RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == CW'(CPB - 1)) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (bit_in) begin
              out_valid <= 1'b1;
              out_data  <= shreg;
            end
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_hp_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int BAUD       = 31_250,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       midi_rx,
  output logic       midi_tx,
  output logic       irq_tx_empty,
  output logic       irq_rx
);
  localparam int CPB = CLK_HZ / BAUD;
  localparam int LW  = $clog2(FIFO_DEPTH) + 1;

  logic uart_mode;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] tx_head, rx_head, rx_din, urx_data;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_pop, tx_push, rx_pop, rx_push;
  logic eng_ready, eng_busy;
  logic urx_valid, urx_ready;
  logic wr_ok, cmd_wr, is_reset, is_uart, ack_push, flush;

  assign wr_ok    = bus_sel && bus_wr && !tx_full;
  assign cmd_wr   = wr_ok && bus_addr;
  assign is_reset = cmd_wr && (bus_wdata == CMD_RESET);
  assign is_uart  = cmd_wr && (bus_wdata == CMD_UART);
  assign ack_push = is_reset || is_uart;
  assign flush    = is_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        uart_mode <= 1'b0;
    else if (is_reset) uart_mode <= 1'b0;
    else if (is_uart)  uart_mode <= 1'b1;
  end

  assign tx_push = wr_ok && !bus_addr && uart_mode;
  assign tx_pop  = !tx_empty && eng_ready;

  midi_hp_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push), .din(bus_wdata),
    .pop(tx_pop && !flush), .dout(tx_head), .empty(tx_empty), .full(tx_full),
    .level(tx_level)
  );

  midi_hp_tx #(.CPB(CPB)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(!tx_empty && !flush), .in_ready(eng_ready),
    .in_data(tx_head), .line(midi_tx), .busy(eng_busy)
  );

  midi_hp_rx #(.CPB(CPB)) u_rx (
    .clk(clk), .rst_n(rst_n), .line(midi_rx), .out_valid(urx_valid),
    .out_ready(urx_ready), .out_data(urx_data)
  );

  assign urx_ready = !ack_push;
  assign rx_pop    = bus_sel && !bus_wr && !bus_addr && !rx_empty;
  assign rx_din    = ack_push ? ACK_BYTE : urx_data;
  always_comb begin
    if (flush)         rx_push = 1'b1;
    else if (ack_push) rx_push = !rx_full;
    else               rx_push = urx_valid && uart_mode && !rx_full;
  end

  midi_hp_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full),
    .level(rx_level)
  );

  always_comb begin
    if (bus_addr)      bus_rdata = {rx_empty, tx_full, 6'b0};
    else if (rx_empty) bus_rdata = 8'h00;
    else               bus_rdata = rx_head;
  end

  assign irq_tx_empty = uart_mode && tx_empty && !eng_busy;
  assign irq_rx       = !rx_empty;

  assert_reset_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_reset |=> (!uart_mode && rx_level == LW'(1) && tx_level == '0));
  assert_enter_uart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_uart |=> uart_mode);
  assert_other_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr && bus_wdata != CMD_RESET && bus_wdata != CMD_UART)
      |=> $stable(uart_mode));
  assert_drop_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr && !uart_mode && !tx_pop) |=> $stable(tx_level));
endmodule

// File: tb/tb_midi_host_port.sv
`timescale 1ns/1ps
module tb_midi_host_port;
  localparam int CPB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic midi_rx = 1'b1;
  logic midi_tx, irq_tx_empty, irq_rx;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] tx_exp [$];

  always #2.5 clk = ~clk;

  midi_host_port #(.CLK_HZ(500_000), .BAUD(31_250), .FIFO_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .midi_rx(midi_rx), .midi_tx(midi_tx), .irq_tx_empty(irq_tx_empty),
    .irq_rx(irq_rx)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic send_txbyte(input logic [7:0] d);
    tx_exp.push_back(d);
    host_write(1'b0, d);
  endtask

  task automatic serial_in(input logic [7:0] d, input logic stop);
    @(negedge clk);
    midi_rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_rx = d[i];
      repeat (CPB) @(negedge clk);
    end
    midi_rx = stop;
    repeat (CPB) @(negedge clk);
    midi_rx = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  // Scoreboard monitor: decodes frames on midi_tx (R8)
  initial begin
    logic [7:0] b;
    logic [7:0] e;
    forever begin
      @(negedge midi_tx);
      repeat (CPB / 2) @(posedge clk);
      #1 chk("R8 start bit", {7'b0, midi_tx}, 8'h00);
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(posedge clk);
        #1 b[i] = midi_tx;
      end
      repeat (CPB) @(posedge clk);
      #1 chk("R8 stop bit", {7'b0, midi_tx}, 8'h01);
      if (tx_exp.size() == 0) begin
        tests++; fails++;
        $display("FAIL R8 unexpected byte got %h expected none", b);
      end else begin
        e = tx_exp.pop_front();
        chk("R8 byte", b, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    host_read(1'b1, r); chk("R12 status", r, 8'h80);
    chk("R12 tx line", {7'b0, midi_tx}, 8'h01);
    chk("R12 irqs", {6'b0, irq_tx_empty, irq_rx}, 8'h00);
    host_read(1'b0, r); chk("R9 empty read", r, 8'h00);

    // R6 data dropped in command mode
    host_write(1'b0, 8'h55);
    repeat (300) @(negedge clk);
    host_read(1'b1, r); chk("R6 status", r, 8'h80);

    // R5 unknown command ignored
    host_write(1'b1, 8'h12);
    host_read(1'b1, r); chk("R5 no ack", r, 8'h80);
    chk("R5 mode unchanged", {7'b0, irq_tx_empty}, 8'h00);

    // R3 enter UART mode, R1 status read has no side effect
    host_write(1'b1, 8'h3F);
    host_read(1'b1, r); chk("R1 status", r, 8'h00);
    host_read(1'b1, r); chk("R1 status again", r, 8'h00);
    chk("R11 irqs", {6'b0, irq_tx_empty, irq_rx}, 8'h03);
    host_read(1'b0, r); chk("R3 ack", r, 8'hFE);
    host_read(1'b1, r); chk("R2 rx empty", r, 8'h80);

    // R8 transmit
    send_txbyte(8'hA5);
    send_txbyte(8'h3C);
    chk("R11 tx busy", {7'b0, irq_tx_empty}, 8'h00);
    repeat (2 * 10 * CPB + 40) @(negedge clk);
    chk("R11 tx idle", {7'b0, irq_tx_empty}, 8'h01);

    // R7 full transmit queue
    for (int i = 0; i < 5; i++) send_txbyte(8'h10 + 8'(i));
    host_read(1'b1, r); chk("R2 tx full", r, 8'hC0);
    host_write(1'b0, 8'hEE);
    repeat (5 * 10 * CPB + 60) @(negedge clk);
    chk("R7 all drained", 8'(tx_exp.size()), 8'h00);

    // R9 receive
    serial_in(8'h81, 1'b1);
    repeat (5) @(negedge clk);
    host_read(1'b1, r); chk("R2 rx waiting", r, 8'h00);
    host_read(1'b0, r); chk("R9 rx byte", r, 8'h81);

    // R10 receive overflow drops the fifth frame
    for (int i = 0; i < 5; i++) serial_in(8'h60 + 8'(i), 1'b1);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      host_read(1'b0, r); chk("R10 rx order", r, 8'h60 + 8'(i));
    end
    host_read(1'b0, r); chk("R10 overflow dropped", r, 8'h00);

    // R10 framing error dropped
    serial_in(8'h5A, 1'b0);
    repeat (40) @(negedge clk);
    host_read(1'b1, r); chk("R10 framing", r, 8'h80);

    // R4 reset command
    serial_in(8'h42, 1'b1);
    repeat (5) @(negedge clk);
    host_write(1'b1, 8'hFF);
    host_read(1'b0, r); chk("R4 ack only", r, 8'hFE);
    host_read(1'b1, r); chk("R4 rx flushed", r, 8'h80);
    chk("R4 left uart mode", {7'b0, irq_tx_empty}, 8'h00);
    host_write(1'b0, 8'h77);
    repeat (300) @(negedge clk);

    // R10 receive outside UART mode
    serial_in(8'h33, 1'b1);
    repeat (10) @(negedge clk);
    host_read(1'b1, r); chk("R10 cmd mode rx", r, 8'h80);
    chk("R11 irq_rx low", {7'b0, irq_rx}, 8'h00);

    chk("R8 queue empty", 8'(tx_exp.size()), 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule